// File: doc/BRIEF.md
# General-Purpose I/O Port with Read-Modify-Write Bit Unit

This block is an eight-pin general-purpose I/O port. Each pin has one direction bit and one output-latch bit. A direction bit of 1 makes the pin an output, and the pin then drives its latch bit. A direction bit of 0 leaves the pin undriven. A read of the port address returns a per-bit mix: an output bit returns its latch value, and an input bit returns its pin level after a two-flop synchronizer.

A small sequencer sits beside the register interface and executes single-bit set, clear and invert requests. Each request reads the mixed port byte, changes one bit, and writes the whole byte back into the output latch. The mixed read is deliberate, so the block reproduces a known hazard. The latch bits of input pins are replaced by whatever levels those pins carry when the read step happens. Software that needs untouched latch bits should keep a shadow copy and use byte writes.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset the direction and latch registers are both 0x00, `pinOe` and `pinOut` are 0x00, and `opBusy` is low.
- R2: A bus write with `regSel`=1 loads the direction register. The new value appears on `pinOe`, and on `busRdata` when `regSel`=1, from the cycle after the write edge.
- R3: A bus write with `regSel`=0 loads all eight latch bits, whatever the direction bits hold. `pinOut` always equals the latch register.
- R4: With `regSel`=0, bit i of `busRdata` is the latch bit when direction bit i is 1. Otherwise it is the pin level seen through the synchronizer. A pin change becomes visible two rising edges after it, and is not visible after one.
- R5: A request with `opCode`=01 (set) is accepted on an edge where `opValid` is high and `opBusy` is low. `opBusy` then stays high for three cycles. On the third edge after acceptance, the latch is loaded with the mixed port byte with bit `opBit` forced to 1.
- R6: `opCode`=10 (clear) follows the same timing and writes the mixed byte with bit `opBit` forced to 0.
- R7: `opCode`=11 (invert) follows the same timing and writes the mixed byte with bit `opBit` inverted.
- R8: Set the direction to 0x3F, the latch to 0x80, pin 7 low and pin 6 high. A set of bit 0 then leaves the latch at 0x41.
- R9: Requests made while `opBusy` is high are ignored. A request with `opCode`=00 is also ignored: it leaves `opBusy` low and does not change the latch.
- R10: If a latch bus write falls on the same edge as the sequencer's write-back, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | Register select: 0 port/latch, 1 direction |
| busWrite | input | 1 | Write strobe for the selected register |
| busWdata | input | WIDTH | Write data |
| busRdata | output | WIDTH | Read data: mixed port byte or direction register |
| opValid | input | 1 | Bit-operation request |
| opCode | input | 2 | 00 none, 01 set, 10 clear, 11 invert |
| opBit | input | BIT_W | Bit index of the request |
| opBusy | output | 1 | Sequencer active |
| pinIn | input | WIDTH | Sampled pin levels |
| pinOut | output | WIDTH | Pin drive levels |
| pinOe | output | WIDTH | Per-pin output enable |

## Verification
Register writes are visible on the ports one edge after the write strobe is sampled. A pin change needs two edges before it reaches the read mux. A bit request shows `opBusy` one edge after acceptance, and the latch holds the result three edges after acceptance. The bench drives on falling edges and samples one falling edge after the due rising edge. It keeps pins stable for at least three edges before each request, so the read step captures a known byte. For the synchronizer it checks both the one-edge and the two-edge points, to prove that the delay is exact.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_INVERT = 2'b11
  } opKind_t;

  typedef struct packed {
    logic    captureRead;
    logic    applyModify;
    logic    commitWrite;
    opKind_t opKind;
  } seqStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [BIT_W-1:0] opBit,
  output seqStrobe_t       strobe,
  output logic [BIT_W-1:0] bitSel,
  output logic             busy
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE
  } seqState_t;

  seqState_t state;
  opKind_t   kindReg;
  logic      accept;

  assign accept = opValid && (state == ST_IDLE) && (opKind_t'(opCode) != OP_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= OP_NONE;
      bitSel  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_READ;
            kindReg <= opKind_t'(opCode);
            bitSel  <= opBit;
          end
        end
        ST_READ:   state <= ST_MODIFY;
        ST_MODIFY: state <= ST_WRITE;
        ST_WRITE:  state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.captureRead = (state == ST_READ);
    strobe.applyModify = (state == ST_MODIFY);
    strobe.commitWrite = (state == ST_WRITE);
    strobe.opKind      = kindReg;
  end

  assign busy = (state != ST_IDLE);

  // R5: an accepted request starts the read step on the next cycle
  assert_accept_starts_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode != 2'b00) |=> strobe.captureRead);

  // R5: the three steps follow each other in order
  assert_read_then_modify_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureRead |=> strobe.applyModify);
  assert_modify_then_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyModify |=> strobe.commitWrite);
  assert_write_ends_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite |=> !busy);

  // R9: a null request never starts the sequencer
  assert_null_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(opValid && opCode != 2'b00)) |=> !busy);

  assert_steps_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.captureRead, strobe.applyModify, strobe.commitWrite}));

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             busWrite,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  seqStrobe_t       strobe,
  input  logic [BIT_W-1:0] bitSel,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latchReg;
  logic [WIDTH-1:0] snapshot;
  logic [WIDTH-1:0] portView;
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] modified;
  logic             wrLatch;
  logic             wrDir;

  // Input synchronizer chain, one stage per generate step
  logic [WIDTH-1:0] syncChain [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= '0;
          else       syncChain[s] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= '0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];

  // Per-bit read mux: outputs return latch, inputs return pin level
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_mix
      assign portView[b] = dirReg[b] ? latchReg[b] : pinSync[b];
    end
  endgenerate

  assign bitMask = WIDTH'(1) << bitSel;

  always_comb begin
    unique case (strobe.opKind)
      OP_SET:    modified = snapshot | bitMask;
      OP_CLEAR:  modified = snapshot & ~bitMask;
      OP_INVERT: modified = snapshot ^ bitMask;
      default:   modified = snapshot;
    endcase
  end

  assign wrLatch = busWrite && !regSel;
  assign wrDir   = busWrite && regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapshot <= '0;
    end else if (strobe.captureRead) begin
      snapshot <= portView;
    end else if (strobe.applyModify) begin
      snapshot <= modified;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
    end else if (strobe.commitWrite) begin
      latchReg <= snapshot;
    end else if (wrLatch) begin
      latchReg <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      dirReg <= '0;
    else if (wrDir) dirReg <= busWdata;
  end

  assign busRdata = regSel ? dirReg : portView;
  assign pinOut   = latchReg;
  assign pinOe    = dirReg;

  // R5: the write step loads the byte built in the modify step
  assert_commit_loads_snapshot_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite |=> (pinOut == $past(snapshot)));

  // R9: without a bus write or write step the latch holds
  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.commitWrite && !wrLatch) |=> $stable(pinOut));

  // R2: direction only moves on a direction write
  assert_dir_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrDir |=> $stable(pinOe));

  // R10: a colliding bus write loses to the write step
  assert_commit_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitWrite && wrLatch) |=> (pinOut == $past(snapshot)));

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             busWrite,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [BIT_W-1:0] opBit,
  output logic             opBusy,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);

  seqStrobe_t       strobe;
  logic [BIT_W-1:0] bitSel;

  gpio_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .opBit   (opBit),
    .strobe  (strobe),
    .bitSel  (bitSel),
    .busy    (opBusy)
  );

  gpio_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .strobe   (strobe),
    .bitSel   (bitSel),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );

endmodule

// File: tb/sim_gpio_rmw_port.sv
module sim_gpio_rmw_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       opValid = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [2:0] opBit = '0;
  logic       opBusy;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_rmw_port u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .opValid(opValid),
    .opCode(opCode), .opBit(opBit), .opBusy(opBusy), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; busWrite = 1'b1; busWdata = val;
    @(negedge clk);
    busWrite = 1'b0; regSel = 1'b0;
  endtask

  function automatic logic [7:0] applyOp(input logic [7:0] v, input logic [1:0] c, input int b);
    logic [7:0] m = 8'(1) << b;
    case (c)
      2'b01:   return v | m;
      2'b10:   return v & ~m;
      2'b11:   return v ^ m;
      default: return v;
    endcase
  endfunction

  // Issue a request and follow its timing; returns on the falling edge after the write edge
  task automatic runOp(input string req, input logic [1:0] c, input int b);
    @(negedge clk);
    opValid = 1'b1; opCode = c; opBit = 3'(b);
    @(negedge clk);
    opValid = 1'b0; opCode = 2'b00;
    check(req, {7'd0, opBusy}, 8'd1);
    @(negedge clk);
    check(req, {7'd0, opBusy}, 8'd1);
    @(negedge clk);
    check(req, {7'd0, opBusy}, 8'd1);
    @(negedge clk);
    check(req, {7'd0, opBusy}, 8'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'd0, 8'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] dirs [4] = '{8'h00, 8'hFF, 8'h3F, 8'hA5};
    logic [7:0] lats [2] = '{8'h80, 8'h5A};
    logic [7:0] pins [2] = '{8'h40, 8'hC3};
    logic [7:0] expv;
    logic [7:0] pv;
    string tag;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 busy", {7'd0, opBusy}, 8'h00);
    regSel = 1'b1; #1;
    check("R1 dir", busRdata, 8'h00);
    regSel = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R2 direction writes; R3 latch writes regardless of direction
    for (int i = 0; i < 4; i++) begin
      busWr(1'b1, dirs[i]);
      check("R2 pinOe", pinOe, dirs[i]);
      regSel = 1'b1; #1;
      check("R2 readback", busRdata, dirs[i]);
      regSel = 1'b0;
      busWr(1'b0, 8'h96 ^ dirs[i]);
      check("R3 pinOut", pinOut, 8'h96 ^ dirs[i]);
    end

    // R4 mixed read and exact synchronizer delay
    busWr(1'b1, 8'hF0);
    busWr(1'b0, 8'hA5);
    pinIn = 8'h00;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 256; p += 17) begin
      pv = (busRdata);
      pinIn = 8'(p);
      @(negedge clk);
      check("R4 one edge", busRdata, pv);
      @(negedge clk);
      check("R4 two edges", busRdata, (8'hA5 & 8'hF0) | (8'(p) & 8'h0F));
    end

    // R5 R6 R7 sweep over op, bit, direction, latch and pins
    for (int d = 0; d < 4; d++)
      for (int l = 0; l < 2; l++)
        for (int q = 0; q < 2; q++)
          for (int c = 1; c < 4; c++)
            for (int b = 0; b < 8; b++) begin
              busWr(1'b1, dirs[d]);
              busWr(1'b0, lats[l]);
              pinIn = pins[q];
              repeat (3) @(negedge clk);
              expv = applyOp((dirs[d] & lats[l]) | (~dirs[d] & pins[q]), 2'(c), b);
              tag = (c == 1) ? "R5 set" : (c == 2) ? "R6 clear" : "R7 invert";
              runOp(tag, 2'(c), b);
              check(tag, pinOut, expv);
            end

    // R8 overwrite of input latch bits
    busWr(1'b1, 8'h3F);
    busWr(1'b0, 8'h80);
    pinIn = 8'h40;
    repeat (3) @(negedge clk);
    runOp("R8", 2'b01, 0);
    check("R8 latch", pinOut, 8'h41);

    // R9 requests while busy are ignored
    busWr(1'b1, 8'hFF);
    busWr(1'b0, 8'h00);
    @(negedge clk);
    opValid = 1'b1; opCode = 2'b01; opBit = 3'd2;
    @(negedge clk);
    opCode = 2'b11; opBit = 3'd5;
    @(negedge clk);
    opCode = 2'b01; opBit = 3'd7;
    @(negedge clk);
    opValid = 1'b0; opCode = 2'b00;
    @(negedge clk);
    check("R9 busy drop", {7'd0, opBusy}, 8'd0);
    check("R9 busy ignore", pinOut, 8'h04);
    // R9 null opcode ignored
    @(negedge clk);
    opValid = 1'b1; opCode = 2'b00; opBit = 3'd2;
    @(negedge clk);
    opValid = 1'b0;
    check("R9 null busy", {7'd0, opBusy}, 8'd0);
    repeat (3) @(negedge clk);
    check("R9 null latch", pinOut, 8'h04);

    // R10 bus write on the write-back edge loses
    @(negedge clk);
    opValid = 1'b1; opCode = 2'b01; opBit = 3'd0;
    @(negedge clk);
    opValid = 1'b0; opCode = 2'b00;
    @(negedge clk);
    @(negedge clk);
    regSel = 1'b0; busWrite = 1'b1; busWdata = 8'hEE;
    @(negedge clk);
    busWrite = 1'b0;
    check("R10 priority", pinOut, 8'h05);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule